// File: doc/BRIEF.md
# Frequency Table Lookup Engine

This block keeps a short table of supported output frequencies. Each row holds a 32-bit frequency and the divider settings that produce it: a 6-bit input divider, a 13-bit feedback multiplier, a 4-bit output divider and a 12-bit bandwidth value. Configuration logic fills the table through a single-row write port. Rows are kept in strictly descending frequency order, and a row whose frequency is zero ends the table.

Two kinds of query arrive over a valid/ready handshake. A round query asks for the closest supported frequency that does not exceed the requested one. When every row is above the request, it falls back to the slowest row. An exact query asks whether the requested frequency is in the table and, if it is, returns that row's divider settings. The engine walks the table one row per clock and marks each answer with a one-cycle done pulse. The answer holds on the result outputs until the next answer replaces it.

Top module: `freq_table_lookup`

## Requirements
- R1: While reset is held and after it is released, `q_ready` is 1, `r_done` is 0 and `r_hit` is 0.
- R2: A query is taken on a clock edge where `q_valid` and `q_ready` are both 1. `q_ready` then stays 0 until the answer arrives. `r_done` is high for exactly one cycle per answer.
- R3: The engine checks one row per clock, starting at row 0. An answer settled on row k shows `r_done` k+1 clock edges after the accepting edge.
- R4: A round query (`q_exact`=0) answers with the first row, counting from row 0, whose frequency is less than or equal to `q_rate`. The answer has `r_hit`=1 and all of that row's fields.
- R5: If no valid row is at or below the request, a round query answers with the last valid row and `r_hit`=1. That row is either the one just before the first zero-frequency row or, in a full table, row DEPTH-1.
- R6: An exact query (`q_exact`=1) whose `q_rate` equals a valid row's frequency answers with `r_hit`=1 and that row's fields.
- R7: An exact query that matches no valid row answers with `r_hit`=0, and every result field is 0.
- R8: The first row whose frequency is zero ends the table. Rows after it never take part in an answer.
- R9: When row 0 has frequency zero, both query kinds answer with a miss (`r_hit`=0, fields 0) on row 0.
- R10: A write with `wr_en`=1 replaces the row at `wr_addr` with the write fields. Every query accepted later sees the new row.
- R11: `q_valid` asserted while `q_ready` is 0 is not taken. It produces no answer and does not change the answer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | 3 | Row index to write (log2 DEPTH) |
| wr_rate | input | 32 | Frequency of the row; 0 marks the end of the table |
| wr_in_div | input | 6 | Input divider setting |
| wr_mult | input | 13 | Feedback multiplier setting |
| wr_out_div | input | 4 | Output divider setting |
| wr_bw | input | 12 | Bandwidth adjust setting |
| q_valid | input | 1 | Query request |
| q_ready | output | 1 | Engine idle; a query is accepted |
| q_exact | input | 1 | 1 = exact query, 0 = round query |
| q_rate | input | 32 | Requested frequency |
| r_done | output | 1 | One-cycle pulse marking a new answer |
| r_hit | output | 1 | Answer carries a valid row |
| r_rate | output | 32 | Frequency of the answering row |
| r_in_div | output | 6 | Input divider of the answering row |
| r_mult | output | 13 | Multiplier of the answering row |
| r_out_div | output | 4 | Output divider of the answering row |
| r_bw | output | 12 | Bandwidth value of the answering row |

## Verification
A wrong scan index or a stale remembered row would surface as the wrong row's fields on the result outputs, or as a fallback row where a direct match was due. Either appears on the first done pulse of the affected query. A scan that stops early or runs late shows as a done pulse off the k+1 edge count, and the bench flags it on that pulse. A stuck state register shows as `q_ready` failing to drop after an accept or failing to return after an answer. That is visible within one cycle of the accept, or as no answer within DEPTH+1 cycles.

// File: rtl/freq_tbl_pkg.sv
package freq_tbl_pkg;
  parameter int RATE_W = 32;
  parameter int NR_W   = 6;
  parameter int NF_W   = 13;
  parameter int NO_W   = 4;
  parameter int BW_W   = 12;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [NR_W-1:0]   in_div;
    logic [NF_W-1:0]   mult;
    logic [NO_W-1:0]   out_div;
    logic [BW_W-1:0]   bw;
  } tbl_entry_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/freq_tbl_store.sv
module freq_tbl_store
  import freq_tbl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [AW-1:0] wr_addr,
  input  tbl_entry_t wr_data,
  input  logic [AW-1:0] rd_addr,
  output tbl_entry_t rd_data
);
  tbl_entry_t slot_view [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    tbl_entry_t row_q;
    logic       row_we;

    assign row_we = wr_en && (wr_addr == AW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_we) begin
        row_q <= wr_data;
      end
    end

    assign slot_view[gi] = row_q;
  end

  assign rd_data = slot_view[rd_addr];
endmodule

// File: rtl/freq_tbl_match.sv
module freq_tbl_match
  import freq_tbl_pkg::*;
(
  input  logic [RATE_W-1:0] row_rate,
  input  logic [RATE_W-1:0] want_rate,
  input  logic              exact_mode,
  output logic              is_end,
  output logic              is_match
);
  always_comb begin
    is_end   = (row_rate == '0);
    is_match = exact_mode ? (row_rate == want_rate) : (row_rate <= want_rate);
  end
endmodule

// File: rtl/freq_table_lookup.sv
module freq_table_lookup
  import freq_tbl_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [RATE_W-1:0]     wr_rate,
  input  logic [NR_W-1:0]       wr_in_div,
  input  logic [NF_W-1:0]       wr_mult,
  input  logic [NO_W-1:0]       wr_out_div,
  input  logic [BW_W-1:0]       wr_bw,
  input  logic                  q_valid,
  output logic                  q_ready,
  input  logic                  q_exact,
  input  logic [RATE_W-1:0]     q_rate,
  output logic                  r_done,
  output logic                  r_hit,
  output logic [RATE_W-1:0]     r_rate,
  output logic [NR_W-1:0]       r_in_div,
  output logic [NF_W-1:0]       r_mult,
  output logic [NO_W-1:0]       r_out_div,
  output logic [BW_W-1:0]       r_bw
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  scan_state_t       state_q, state_d;
  logic [AW-1:0]     idx_q, idx_d;
  logic [RATE_W-1:0] req_q, req_d;
  logic              exact_q, exact_d;
  tbl_entry_t        prev_q, prev_d;
  logic              done_q, done_d;
  logic              hit_q, hit_d;
  tbl_entry_t        res_q, res_d;

  tbl_entry_t wr_row, cur_row, fin_row;
  logic       accept, scanning, finish, fin_hit;
  logic       row_end, row_match;

  assign wr_row = '{rate: wr_rate, in_div: wr_in_div, mult: wr_mult,
                    out_div: wr_out_div, bw: wr_bw};

  freq_tbl_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_row),
    .rd_addr (idx_q),
    .rd_data (cur_row)
  );

  freq_tbl_match u_match (
    .row_rate   (cur_row.rate),
    .want_rate  (req_q),
    .exact_mode (exact_q),
    .is_end     (row_end),
    .is_match   (row_match)
  );

  assign scanning = (state_q == ST_SCAN);
  assign accept   = q_valid && (state_q == ST_IDLE);

  // Decide whether the row under examination settles the answer
  always_comb begin
    finish  = 1'b0;
    fin_hit = 1'b0;
    fin_row = cur_row;
    if (scanning) begin
      if (row_end) begin
        finish  = 1'b1;
        fin_hit = !exact_q && (idx_q != '0);
        fin_row = prev_q;
      end else if (row_match) begin
        finish  = 1'b1;
        fin_hit = 1'b1;
      end else if (idx_q == LAST_IDX) begin
        finish  = 1'b1;
        fin_hit = !exact_q;
      end
    end
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    req_d   = req_q;
    exact_d = exact_q;
    prev_d  = prev_q;
    done_d  = finish;
    hit_d   = hit_q;
    res_d   = res_q;
    if (accept) begin
      state_d = ST_SCAN;
      idx_d   = '0;
      req_d   = q_rate;
      exact_d = q_exact;
    end else if (scanning) begin
      prev_d = cur_row;
      if (finish) begin
        state_d = ST_IDLE;
        hit_d   = fin_hit;
        res_d   = fin_hit ? fin_row : '0;
      end else begin
        idx_d = idx_q + AW'(1);
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      req_q   <= '0;
      exact_q <= 1'b0;
      prev_q  <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      req_q   <= req_d;
      exact_q <= exact_d;
      prev_q  <= prev_d;
      done_q  <= done_d;
      hit_q   <= hit_d;
      res_q   <= res_d;
    end
  end

  assign q_ready   = (state_q == ST_IDLE);
  assign r_done    = done_q;
  assign r_hit     = hit_q;
  assign r_rate    = res_q.rate;
  assign r_in_div  = res_q.in_div;
  assign r_mult    = res_q.mult;
  assign r_out_div = res_q.out_div;
  assign r_bw      = res_q.bw;

  // Independent scan-length counter used by the watchdog property
  logic [AW:0] scan_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_len_q <= '0;
    end else if (accept) begin
      scan_len_q <= '0;
    end else if (scanning) begin
      scan_len_q <= scan_len_q + (AW+1)'(1);
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_done |=> !r_done);

  // R2
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ready) |=> !q_ready);

  // R3
  scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanning |-> (scan_len_q < (AW+1)'(DEPTH)));

  // R6
  exact_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_done && r_hit && exact_q) |-> (r_rate == req_q));

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_done && !r_hit) |-> (r_rate == '0 && r_in_div == '0 && r_mult == '0
                            && r_out_div == '0 && r_bw == '0));
endmodule

// File: tb/freq_table_lookup_test.sv
module freq_table_lookup_test;
  localparam int DEPTH = 8;

  typedef struct {
    logic        hit;
    logic [31:0] rate;
    logic [5:0]  in_div;
    logic [12:0] mult;
    logic [3:0]  out_div;
    logic [11:0] bw;
    int          steps;
    int          acc;
    string       tag;
  } exp_t;

  logic        clk, rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_rate;
  logic [5:0]  wr_in_div;
  logic [12:0] wr_mult;
  logic [3:0]  wr_out_div;
  logic [11:0] wr_bw;
  logic        q_valid, q_ready, q_exact;
  logic [31:0] q_rate;
  logic        r_done, r_hit;
  logic [31:0] r_rate;
  logic [5:0]  r_in_div;
  logic [12:0] r_mult;
  logic [3:0]  r_out_div;
  logic [11:0] r_bw;

  freq_table_lookup #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_rate(wr_rate),
    .wr_in_div(wr_in_div), .wr_mult(wr_mult), .wr_out_div(wr_out_div), .wr_bw(wr_bw),
    .q_valid(q_valid), .q_ready(q_ready), .q_exact(q_exact), .q_rate(q_rate),
    .r_done(r_done), .r_hit(r_hit), .r_rate(r_rate), .r_in_div(r_in_div),
    .r_mult(r_mult), .r_out_div(r_out_div), .r_bw(r_bw)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  exp_t sb[$];

  logic [31:0] m_rate [DEPTH];
  logic [5:0]  m_nr   [DEPTH];
  logic [12:0] m_nf   [DEPTH];
  logic [3:0]  m_no   [DEPTH];
  logic [11:0] m_bw   [DEPTH];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic write_row(input int idx, input logic [31:0] rate);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(idx); wr_rate = rate;
    wr_in_div = 6'(idx + 1); wr_mult = rate[12:0] ^ 13'h05a;
    wr_out_div = 4'(idx + 2); wr_bw = rate[15:4];
    m_rate[idx] = rate; m_nr[idx] = wr_in_div; m_nf[idx] = wr_mult;
    m_no[idx] = wr_out_div; m_bw[idx] = wr_bw;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic exp_t model(input logic exact, input logic [31:0] req);
    exp_t e;
    int pick;
    e.hit = 1'b0; e.steps = 0; pick = -1;
    for (int i = 0; i < DEPTH; i++) begin
      e.steps = i;
      if (m_rate[i] == 0) begin
        if (!exact && i != 0) pick = i - 1;
        break;
      end
      if (exact ? (m_rate[i] == req) : (m_rate[i] <= req)) begin
        pick = i;
        break;
      end
      if (i == DEPTH - 1 && !exact) pick = i;
    end
    if (pick >= 0) begin
      e.hit = 1'b1; e.rate = m_rate[pick]; e.in_div = m_nr[pick];
      e.mult = m_nf[pick]; e.out_div = m_no[pick]; e.bw = m_bw[pick];
    end else begin
      e.rate = '0; e.in_div = '0; e.mult = '0; e.out_div = '0; e.bw = '0;
    end
    return e;
  endfunction

  // Driver: issues one query and pushes its expected answer
  task automatic query(input logic exact, input logic [31:0] req, input string tag);
    exp_t e;
    @(negedge clk);
    while (!q_ready) @(negedge clk);
    q_valid = 1'b1; q_exact = exact; q_rate = req;
    e = model(exact, req);
    e.tag = tag;
    @(negedge clk);
    q_valid = 1'b0;
    e.acc = cyc;
    sb.push_back(e);
    check("R2", q_ready == 1'b0, "ready after accept", 32'(q_ready), 0);
  endtask

  // Monitor: compares each answer against the scoreboard
  always @(negedge clk) begin
    if (rst_n && r_done) begin
      if (sb.size() == 0) begin
        check("R11", 1'b0, "unexpected answer", r_rate, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, r_hit == e.hit, "hit", 32'(r_hit), 32'(e.hit));
        check(e.tag, r_rate == e.rate, "rate", r_rate, e.rate);
        check(e.tag, {r_in_div, r_mult, r_out_div, r_bw} ==
                     {e.in_div, e.mult, e.out_div, e.bw}, "settings",
              32'({r_in_div, r_mult, r_out_div}), 32'({e.in_div, e.mult, e.out_div}));
        check("R3", cyc - e.acc == e.steps + 1, "latency",
              32'(cyc - e.acc), 32'(e.steps + 1));
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while (sb.size() != 0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    check("R2", sb.size() == 0, "answer outstanding", 32'(sb.size()), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_rate = '0; wr_in_div = '0;
    wr_mult = '0; wr_out_div = '0; wr_bw = '0;
    q_valid = 1'b0; q_exact = 1'b0; q_rate = '0;
    for (int i = 0; i < DEPTH; i++) begin
      m_rate[i] = '0; m_nr[i] = '0; m_nf[i] = '0; m_no[i] = '0; m_bw[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1", q_ready == 1'b1, "ready in reset", 32'(q_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", q_ready == 1'b1 && r_done == 1'b0 && r_hit == 1'b0,
          "idle after reset", 32'({q_ready, r_done, r_hit}), 32'h4);

    // R9: empty table
    query(1'b0, 32'd500_000_000, "R9");
    query(1'b1, 32'd500_000_000, "R9");
    drain();

    // R10: load table, zero marker at row 5
    write_row(0, 32'd1_200_000_000);
    write_row(1, 32'd1_000_000_000);
    write_row(2, 32'd800_000_000);
    write_row(3, 32'd600_000_000);
    write_row(4, 32'd400_000_000);

    // R4: round picks first row at or below request
    query(1'b0, 32'd1_300_000_000, "R4");
    query(1'b0, 32'd1_000_000_000, "R4");
    query(1'b0, 32'd900_000_000, "R4");
    query(1'b0, 32'd600_000_000, "R4");
    // R5: fallback through the end marker
    query(1'b0, 32'd100_000_000, "R5");
    query(1'b0, 32'd0, "R5");
    // R6 / R7: exact hits and misses
    query(1'b1, 32'd800_000_000, "R6");
    query(1'b1, 32'd400_000_000, "R6");
    query(1'b1, 32'd850_000_000, "R7");
    query(1'b1, 32'd100_000_000, "R7");
    drain();

    // R8: row beyond the zero marker is ignored
    write_row(6, 32'd300_000_000);
    query(1'b1, 32'd300_000_000, "R8");
    query(1'b0, 32'd350_000_000, "R8");
    drain();

    // R5: full table fallback to the last slot
    write_row(5, 32'd300_000_000);
    write_row(6, 32'd200_000_000);
    write_row(7, 32'd100_000_000);
    query(1'b0, 32'd50_000_000, "R5");
    query(1'b1, 32'd100_000_000, "R6");
    query(1'b1, 32'd90_000_000, "R7");
    drain();

    // R11: valid while busy is not taken
    query(1'b0, 32'd250_000_000, "R11");
    forever begin
      @(negedge clk);
      if (q_ready) break;
      q_valid = 1'b1; q_exact = 1'b1; q_rate = 32'd1_200_000_000;
    end
    q_valid = 1'b0;
    repeat (12) @(negedge clk);
    check("R11", sb.size() == 0, "queue after busy", 32'(sb.size()), 0);

    // R10: rewrite a row
    write_row(0, 32'd1_500_000_000);
    query(1'b0, 32'd2_000_000_000, "R10");
    query(1'b1, 32'd1_200_000_000, "R10");
    drain();

    // R9: empty again via row 0 cleared
    write_row(0, 32'd0);
    query(1'b0, 32'd700_000_000, "R9");
    query(1'b1, 32'd1_000_000_000, "R9");
    drain();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule